// File: doc/BRIEF.md
# Bank Address Demultiplexing Glue

This block sits between a processor with a 16-bit address bus and the memory and peripheral devices around it. The processor puts the upper address byte (the bank) on its data bus while the phase clock `phi2` is low. The block samples the data bus in that phase and keeps the last bank value steady for the whole high phase. It joins that bank to the 16-bit address to form a 24-bit effective address and decodes it into four selects: low RAM, I/O, ROM and high RAM.

The block gives active-low read and write strobes that only assert while `phi2` is high. It also drives the enable and direction of an external bus transceiver, so that no device drives the processor data bus while the bank byte is on it.

The `flat_map` input turns the bank byte off completely and gives a plain 64K map. The processor's valid-address qualifiers gate every select. The design is synchronous to a fast system clock, and `phi2` is sampled as a level.

Top module: `bank_demux_glue`

## Requirements
- R1: On every `clk` edge where `rst_n` is high and `phi2` is low, the block loads the bank register from `dbus`. Outside reset and with `flat_map` low, `eff_addr[23:16]` equals that register and `eff_addr[15:0]` equals `addr`.
- R2: On a `clk` edge where `phi2` is high, the bank register keeps its value, whatever `dbus` carries.
- R3: With the effective bank at 0x00 and `addr` from 0x0000 to 0xBFFF, `cs_lo_ram` is 1 and the other selects are 0.
- R4: With the effective bank at 0x00, `addr` from 0xC000 to 0xCFFF selects only `cs_io`, and `addr` from 0xD000 to 0xFFFF selects only `cs_rom`.
- R5: A bank from 0x01 to 0x07 selects only `cs_hi_ram`, at any `addr`. A bank of 0x08 or above asserts no select. At most one select is ever high.
- R6: When `flat_map` is 1, the effective bank is 0x00 (`eff_addr[23:16]` = 0). The bank register then has no effect, and `cs_hi_ram` stays 0.
- R7: When `vda` and `vpa` are both 0, all selects are 0 and both strobes are 1.
- R8: `rd_n` is 0 exactly when `phi2` is 1, `rw` is 1 (read), a select is active, and the block is out of reset.
- R9: `wr_n` is 0 exactly when `phi2` is 1, `rw` is 0 (write), a select is active, and the block is out of reset. `rd_n` and `wr_n` are never both 0.
- R10: `xcvr_en_n` is 1 while `phi2` is 0 and 0 while `phi2` is 1 (once out of reset). `xcvr_dir` follows `rw`, with 1 meaning system-to-processor.
- R11: A `clk` edge with `rst_n` low clears the bank register to 0x00 and marks the block not ready. Until the first edge with `rst_n` high, all selects are 0 and `rd_n`, `wr_n` and `xcvr_en_n` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than phi2 |
| rst_n | input | 1 | Synchronous active-low reset |
| phi2 | input | 1 | Processor phase clock, sampled as a level |
| rw | input | 1 | 1 = read, 0 = write |
| vda | input | 1 | Valid data address qualifier |
| vpa | input | 1 | Valid program address qualifier |
| flat_map | input | 1 | 1 = ignore bank, plain 64K map |
| addr | input | 16 | Processor address bus |
| dbus | input | 8 | Processor data bus (carries bank while phi2 low) |
| eff_addr | output | 24 | Effective address |
| cs_lo_ram | output | 1 | Low RAM select |
| cs_io | output | 1 | I/O select |
| cs_rom | output | 1 | ROM select |
| cs_hi_ram | output | 1 | High RAM select |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| xcvr_en_n | output | 1 | Transceiver enable, active low |
| xcvr_dir | output | 1 | Transceiver direction |

## Verification
The collision that matters is a bank load and a strobe decision in the same cycle. On the last low-phase clock edge, the bank register takes a new value, and from the next edge on the high phase's strobes are decoded with it, while `dbus` already carries unrelated data. The bench drives junk on `dbus` through every high phase and changes the bank between bus cycles. It compares the effective address, selects and strobes on every clock against a behavioural model that holds its own bank value. Random cycles that switch `flat_map`, the qualifiers and `rw`, plus a reset in mid-run, put these events into the same clocks in many combinations.

// File: rtl/glue_pkg.sv
// Shared types for the bank demultiplexing glue.
// Assumes: one select per decoded region, active high.
package glue_pkg;
    typedef struct packed {
        logic lo;
        logic io;
        logic rom;
        logic hi;
    } sel_t;
endpackage

// File: rtl/bank_capture.sv
// Bank capture: loads the bank byte from the data bus on each clock edge
// while phi2 is low and holds it through the high phase. It also flags
// readiness, which is set on the first edge after reset is released.
// Assumes: clk is much faster than phi2, so each low phase has at least one edge.
module bank_capture #(
    parameter int BANK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phi2,
    input  logic [BANK_W-1:0] dbus,
    output logic [BANK_W-1:0] bank_q,
    output logic              live_q
);
    // Load the bank during the low phase, hold it in the high phase.
    always_ff @(posedge clk) begin
        if (!rst_n)     bank_q <= '0;
        else if (!phi2) bank_q <= dbus;
    end

    // Readiness flag: clear during reset, set on the first edge after it.
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    // R2: a high-phase edge leaves the bank register unchanged.
    p_hold_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(phi2)) |-> $stable(bank_q));

    // R11: a reset edge leaves the bank at zero and not ready.
    p_reset_clear_r11: assert property (@(posedge clk)
        $past(!rst_n) |-> (bank_q == '0 && !live_q));
endmodule

// File: rtl/addr_decode.sv
// Address decode: forms the effective address from bank and address and
// decodes it into one of four region selects.
// Assumes: regions lie in bank zero except high RAM, and high RAM spans
// a contiguous bank range.
module addr_decode
    import glue_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int BANK_W   = 8,
    parameter logic [ADDR_W-1:0] LO_TOP   = 16'hBFFF,
    parameter logic [ADDR_W-1:0] IO_BASE  = 16'hC000,
    parameter logic [ADDR_W-1:0] IO_TOP   = 16'hCFFF,
    parameter logic [BANK_W-1:0] HI_FIRST = 8'h01,
    parameter logic [BANK_W-1:0] HI_LAST  = 8'h07,
    localparam int EA_W = ADDR_W + BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] bank,
    input  logic [ADDR_W-1:0] addr,
    input  logic              flat_map,
    input  logic              live,
    input  logic              vda,
    input  logic              vpa,
    output logic [EA_W-1:0]   eff_addr,
    output sel_t              sel
);
    logic [BANK_W-1:0] eff_bank;
    logic              valid;
    logic              base_bank;

    // Choose the effective bank: forced to zero in the flat map.
    always_comb begin
        eff_bank = flat_map ? '0 : bank;
        eff_addr = {eff_bank, addr};
    end

    // Region decode, gated by readiness and the address qualifiers.
    always_comb begin
        valid     = live && (vda || vpa);
        base_bank = (eff_bank == '0);
        sel.lo    = valid && base_bank && (addr <= LO_TOP);
        sel.io    = valid && base_bank && (addr >= IO_BASE) && (addr <= IO_TOP);
        sel.rom   = valid && base_bank && (addr > IO_TOP);
        sel.hi    = valid && (eff_bank >= HI_FIRST) && (eff_bank <= HI_LAST);
    end

    // R5: at most one region is ever selected.
    p_one_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel.lo, sel.io, sel.rom, sel.hi}));

    // R6: the flat map never selects high RAM.
    p_flat_no_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flat_map |-> !sel.hi);

    // R7: an internal cycle selects nothing.
    p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!vda && !vpa) |-> (sel == '0));
endmodule

// File: rtl/strobe_gen.sv
// Strobe generation: phase-qualified read and write strobes, and the
// control for the external data-bus transceiver.
// Assumes: rw = 1 means read; the transceiver direction 1 means system to processor.
module strobe_gen
    import glue_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic phi2,
    input  logic rw,
    input  logic live,
    input  sel_t sel,
    output logic rd_n,
    output logic wr_n,
    output logic xcvr_en_n,
    output logic xcvr_dir
);
    logic any_sel;
    logic open_phase;

    // Strobes only in the high phase, with a select and the block ready.
    always_comb begin
        any_sel    = sel.lo || sel.io || sel.rom || sel.hi;
        open_phase = live && phi2;
        rd_n       = !(open_phase && any_sel && rw);
        wr_n       = !(open_phase && any_sel && !rw);
        xcvr_en_n  = !open_phase;
        xcvr_dir   = rw;
    end

    // R8: no read strobe in the bank-carrying phase.
    p_rd_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !phi2 |-> rd_n);

    // R9: no write strobe in the low phase, never both strobes.
    p_wr_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !phi2 |-> wr_n);
    p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_n || wr_n));

    // R10: the transceiver is isolated while phi2 is low.
    p_iso_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !phi2 |-> xcvr_en_n);
endmodule

// File: rtl/bank_demux_glue.sv
// Top level of the bank demultiplexing glue: bank capture, address decode
// and strobe generation.
// Assumes: synchronous active-low reset; phi2 sampled by clk as a level.
module bank_demux_glue
    import glue_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BANK_W = 8,
    localparam int EA_W  = ADDR_W + BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phi2,
    input  logic              rw,
    input  logic              vda,
    input  logic              vpa,
    input  logic              flat_map,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BANK_W-1:0] dbus,
    output logic [EA_W-1:0]   eff_addr,
    output logic              cs_lo_ram,
    output logic              cs_io,
    output logic              cs_rom,
    output logic              cs_hi_ram,
    output logic              rd_n,
    output logic              wr_n,
    output logic              xcvr_en_n,
    output logic              xcvr_dir
);
    logic [BANK_W-1:0] bank_q;
    logic              live_q;
    sel_t              sel;

    bank_capture #(.BANK_W(BANK_W)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .phi2   (phi2),
        .dbus   (dbus),
        .bank_q (bank_q),
        .live_q (live_q)
    );

    addr_decode #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .bank     (bank_q),
        .addr     (addr),
        .flat_map (flat_map),
        .live     (live_q),
        .vda      (vda),
        .vpa      (vpa),
        .eff_addr (eff_addr),
        .sel      (sel)
    );

    strobe_gen u_stb (
        .clk       (clk),
        .rst_n     (rst_n),
        .phi2      (phi2),
        .rw        (rw),
        .live      (live_q),
        .sel       (sel),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .xcvr_en_n (xcvr_en_n),
        .xcvr_dir  (xcvr_dir)
    );

    // Route the region selects to the ports.
    always_comb begin
        cs_lo_ram = sel.lo;
        cs_io     = sel.io;
        cs_rom    = sel.rom;
        cs_hi_ram = sel.hi;
    end

    // R7: an internal cycle raises no strobe.
    p_idle_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!vda && !vpa) |-> (rd_n && wr_n));
endmodule

// File: tb/bank_demux_glue_tb.sv
module bank_demux_glue_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phi2 = 1'b0, rw = 1'b1, vda = 1'b0, vpa = 1'b0, flat_map = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  dbus = '0;
    logic [23:0] eff_addr;
    logic        cs_lo_ram, cs_io, cs_rom, cs_hi_ram, rd_n, wr_n, xcvr_en_n, xcvr_dir;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit done = 0;

    // model state
    bit       m_init = 0;
    bit       m_live = 0;
    bit [7:0] m_bank = 0;

    always #5 clk = ~clk;

    bank_demux_glue u_dut (
        .clk(clk), .rst_n(rst_n), .phi2(phi2), .rw(rw), .vda(vda), .vpa(vpa),
        .flat_map(flat_map), .addr(addr), .dbus(dbus), .eff_addr(eff_addr),
        .cs_lo_ram(cs_lo_ram), .cs_io(cs_io), .cs_rom(cs_rom), .cs_hi_ram(cs_hi_ram),
        .rd_n(rd_n), .wr_n(wr_n), .xcvr_en_n(xcvr_en_n), .xcvr_dir(xcvr_dir)
    );

    task automatic chk(input string req, input string name, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", req, name, act, exp);
        end
    endtask

    // Drive one clock of inputs, compare against the model, then advance the model.
    task automatic step(input bit r, input bit p, input bit [7:0] d, input bit [15:0] a,
                        input bit w_r, input bit qa, input bit qp, input bit fl);
        bit [7:0]  eb;
        bit        valid, lo, io, rom, hi, any, open;
        string     ctx;
        @(negedge clk);
        rst_n = r; phi2 = p; dbus = d; addr = a; rw = w_r; vda = qa; vpa = qp; flat_map = fl;
        #2;
        if (m_init) begin
            eb    = fl ? 8'h00 : m_bank;
            valid = m_live && (qa || qp);
            lo    = valid && eb == 0 && a <= 16'hBFFF;
            io    = valid && eb == 0 && a >= 16'hC000 && a <= 16'hCFFF;
            rom   = valid && eb == 0 && a >= 16'hD000;
            hi    = valid && eb >= 8'h01 && eb <= 8'h07;
            any   = lo || io || rom || hi;
            open  = m_live && p;
            ctx   = !m_live ? "R11" : (!(qa || qp) ? "R7" : (fl ? "R6" : ""));
            chk(fl ? "R6" : (p ? "R2" : "R1"), "eff_addr", int'(eff_addr), int'({eb, a}));
            chk(ctx == "" ? "R3" : ctx, "cs_lo_ram", int'(cs_lo_ram), int'(lo));
            chk(ctx == "" ? "R4" : ctx, "cs_io", int'(cs_io), int'(io));
            chk(ctx == "" ? "R4" : ctx, "cs_rom", int'(cs_rom), int'(rom));
            chk(ctx == "" ? "R5" : ctx, "cs_hi_ram", int'(cs_hi_ram), int'(hi));
            chk(ctx == "" ? "R8" : ctx, "rd_n", int'(rd_n), int'(!(open && any && w_r)));
            chk(ctx == "" ? "R9" : ctx, "wr_n", int'(wr_n), int'(!(open && any && !w_r)));
            chk(m_live ? "R10" : "R11", "xcvr_en_n", int'(xcvr_en_n), int'(!open));
            chk("R10", "xcvr_dir", int'(xcvr_dir), int'(w_r));
        end
        @(posedge clk);
        if (!r) begin
            m_bank = 0; m_live = 0; m_init = 1;
        end else if (m_init) begin
            m_live = 1;
            if (!p) m_bank = d;
        end
    endtask

    // One processor bus cycle: two low-phase clocks with the bank, two high with junk data.
    task automatic bus(input bit [7:0] bank, input bit [15:0] a, input bit w_r,
                       input bit qa, input bit qp, input bit fl);
        step(1, 0, bank, a, w_r, qa, qp, fl);
        step(1, 0, bank, a, w_r, qa, qp, fl);
        step(1, 1, ~bank, a, w_r, qa, qp, fl);
        step(1, 1, 8'($urandom), a, w_r, qa, qp, fl);
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        // R11: reset holds everything idle even with valid cycles requested
        for (int i = 0; i < 3; i++) step(0, i[0], 8'h05, 16'h1234, 1'b1, 1'b1, 1'b1, 1'b0);
        // first cycle out of reset: not ready yet
        step(1, 1, 8'h03, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0);
        // R3 boundaries
        bus(8'h00, 16'h0000, 1, 1, 0, 0);
        bus(8'h00, 16'hBFFF, 0, 0, 1, 0);
        // R4 boundaries
        bus(8'h00, 16'hC000, 1, 1, 1, 0);
        bus(8'h00, 16'hCFFF, 0, 1, 0, 0);
        bus(8'h00, 16'hD000, 1, 1, 0, 0);
        bus(8'h00, 16'hFFFF, 1, 0, 1, 0);
        // R5: high RAM banks and unmapped banks
        bus(8'h01, 16'h0000, 0, 1, 0, 0);
        bus(8'h07, 16'hFFFF, 1, 1, 0, 0);
        bus(8'h08, 16'h0000, 1, 1, 0, 0);
        bus(8'hFF, 16'h1234, 0, 1, 0, 0);
        // R6: flat map ignores the bank
        bus(8'h03, 16'h4000, 1, 1, 0, 1);
        bus(8'h40, 16'hC800, 0, 1, 0, 1);
        bus(8'h02, 16'hE000, 1, 0, 1, 1);
        // R7: internal cycles
        bus(8'h02, 16'h0100, 1, 0, 0, 0);
        bus(8'h00, 16'h0100, 0, 0, 0, 0);
        // R1 R2 R8 R9 R10: random mixes
        for (int i = 0; i < 400; i++) begin
            bus(8'($urandom_range(0, 12)), 16'($urandom), 1'($urandom), 1'($urandom),
                1'($urandom), ($urandom_range(0, 3) == 0));
        end
        // R11: reset in mid-run
        step(1, 0, 8'h06, 16'h2000, 1, 1, 0, 0);
        step(0, 1, 8'h06, 16'h2000, 1, 1, 0, 0);
        step(1, 1, 8'h06, 16'h2000, 1, 1, 0, 0);
        step(1, 1, 8'h06, 16'h2000, 0, 1, 0, 0);
        for (int i = 0; i < 200; i++) begin
            step(1, 1'($urandom), 8'($urandom), 16'($urandom), 1'($urandom), 1'($urandom),
                 1'($urandom), ($urandom_range(0, 3) == 0));
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule